// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block links two 9-bit ports, A and B. Each port carries eight data bits and one parity bit. Each bus is split into an input word, an output word and an output-enable. Two active-low direction enables select which port the block drives. Each side has its own latch, which is either open or holding. Data that flows from one side's latch goes out on the other port.

A mode input selects the source of the outgoing parity bit. In generate mode the block computes that bit from the eight data bits. In pass-through mode it copies the received parity bit unchanged. A sense input chooses odd or even parity.

Each side has an active-low error flag. The flag compares the parity computed from that side's latch contents with the parity bit in that latch, and it works in both modes. The driven port's latch sees the word the block is driving. Because of this, generated parity loops back and both flags can be read at once.

The latches suit a synchronous design. While a side's latch enable is high, its contents follow the bus in the same cycle. While the enable is low, the latch holds the word it captured at the last rising clock edge where the enable was high. The control pins are plain level signals with no handshake, because nothing at this block's edge can stall.

Top module: `ptx_xcvr`

## Requirements
- R1: `b_oe` is high whenever `en_a2b_n` is low. `a_oe` is high only when `en_a2b_n` is high and `en_b2a_n` is low. Both are low when both enables are high, and the two are never high together (A-to-B wins).
- R2: While a port is driven, its data bits equal the data field of the opposite side's latch. With that latch open, they equal the opposite input in the same cycle.
- R3: In generate mode (`pass_par` = 0), the driven parity bit is the XOR of the eight driven data bits, XORed with `odd_par`.
- R4: In pass-through mode (`pass_par` = 1), the driven parity bit equals the parity bit held in the opposite side's latch.
- R5: `odd_par` = 1 selects odd parity and `odd_par` = 0 selects even parity. In generate mode, the nine driven bits then hold an odd or an even number of ones respectively.
- R6: `a_bad_n` (and `b_bad_n`) is low exactly when the XOR of that side's latched data bits, XORed with `odd_par`, differs from that side's latched parity bit. This holds in both modes.
- R7: While a side's latch enable is low, that side's latch keeps the word captured at the last rising edge with the enable high. Input changes on that side then alter neither the opposite port's output nor the side's error flag.
- R8: On the driven side with its latch open, the latch sees the driven word. In generate mode that side's flag stays high. In pass-through mode the flag reports the copied parity against the data.
- R9: During and just after reset, with both latches closed, both latches read all zeros. With even parity and both enables high, both flags are high and all outputs are zero.
- R10: A port that is not driven shows all-zero data and parity outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch hold registers |
| rst_n | input | 1 | Asynchronous active-low reset of the held words |
| en_a2b_n | input | 1 | Active-low enable to drive port B from side A |
| en_b2a_n | input | 1 | Active-low enable to drive port A from side B |
| pass_par | input | 1 | 1: copy received parity; 0: generate parity |
| odd_par | input | 1 | 1: odd parity; 0: even parity |
| a_le | input | 1 | Side A latch open while high |
| b_le | input | 1 | Side B latch open while high |
| a_in | input | 8 | Port A data seen on the bus |
| a_par_in | input | 1 | Port A parity seen on the bus |
| a_out | output | 8 | Port A data driven by the block |
| a_par_out | output | 1 | Port A parity driven by the block |
| a_oe | output | 1 | Port A output enable |
| b_in | input | 8 | Port B data seen on the bus |
| b_par_in | input | 1 | Port B parity seen on the bus |
| b_out | output | 8 | Port B data driven by the block |
| b_par_out | output | 1 | Port B parity driven by the block |
| b_oe | output | 1 | Port B output enable |
| a_bad_n | output | 1 | Side A parity error, low on mismatch |
| b_bad_n | output | 1 | Side B parity error, low on mismatch |

## Verification
The properties assume that all control and bus inputs are stable across each rising clock edge, so each held word is well defined. The stimulus applies every change on the falling edge and samples shortly after it, well before the next capture. The hold property also assumes the driven direction does not change while it watches the output. The bench sweeps every combination of the six control inputs and flips the received parity bits from round to round. Every mismatch case is therefore reached in both modes and with both latch states.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_A2B  = 2'd1,
    DIR_B2A  = 2'd2
  } dir_e;

  localparam int SIDE_A = 0;
  localparam int SIDE_B = 1;
endpackage

// File: rtl/ptx_parity.sv
module ptx_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         odd,
  output logic         par
);
  // reduction XOR gives the even-parity bit; odd sense inverts it
  assign par = (^data) ^ odd;
endmodule

// File: rtl/ptx_dir_ctl.sv
module ptx_dir_ctl
  import ptx_pkg::*;
(
  input  logic en_a2b_n,
  input  logic en_b2a_n,
  output dir_e dir
);
  // A-to-B has priority so the ports can never drive each other
  always_comb begin
    if (!en_a2b_n)      dir = DIR_A2B;
    else if (!en_b2a_n) dir = DIR_B2A;
    else                dir = DIR_IDLE;
  end
endmodule

// File: rtl/ptx_hold_latch.sv
module ptx_hold_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         use_drv,
  input  logic [W-1:0] d_raw,
  input  logic [W-1:0] d_drv,
  output logic [W-1:0] q_src,
  output logic [W-1:0] q_chk
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held <= '0;
    else if (le) held <= q_chk;
  end

  // q_src feeds the opposite port and never sees the driven word,
  // which keeps the forward path free of a loop through this side.
  assign q_src = le ? d_raw : held;
  assign q_chk = le ? (use_drv ? d_drv : d_raw) : held;
endmodule

// File: rtl/ptx_xcvr.sv
module ptx_xcvr
  import ptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a2b_n,
  input  logic              en_b2a_n,
  input  logic              pass_par,
  input  logic              odd_par,
  input  logic              a_le,
  input  logic              b_le,
  input  logic [DATA_W-1:0] a_in,
  input  logic              a_par_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_par_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  input  logic              b_par_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_par_out,
  output logic              b_oe,
  output logic              a_bad_n,
  output logic              b_bad_n
);
  localparam int LW     = DATA_W + 1;
  localparam int NSIDES = 2;

  dir_e dir;

  ptx_dir_ctl u_dir (
    .en_a2b_n (en_a2b_n),
    .en_b2a_n (en_b2a_n),
    .dir      (dir)
  );

  logic [NSIDES-1:0] drives;
  logic [NSIDES-1:0] le;
  logic [NSIDES-1:0] gen_src;
  logic [NSIDES-1:0] gen_chk;
  logic [NSIDES-1:0] bad_n;
  logic [LW-1:0]     raw [NSIDES];
  logic [LW-1:0]     src [NSIDES];
  logic [LW-1:0]     chk [NSIDES];
  logic [LW-1:0]     fwd [NSIDES];  // word the block drives onto side i

  assign drives[SIDE_A] = (dir == DIR_B2A);
  assign drives[SIDE_B] = (dir == DIR_A2B);
  assign le[SIDE_A]     = a_le;
  assign le[SIDE_B]     = b_le;
  assign raw[SIDE_A]    = {a_in, a_par_in};
  assign raw[SIDE_B]    = {b_in, b_par_in};

  for (genvar i = 0; i < NSIDES; i++) begin : g_side
    ptx_parity #(.W(DATA_W)) u_gen_src (
      .data (src[i][LW-1:1]),
      .odd  (odd_par),
      .par  (gen_src[i])
    );

    // outgoing word toward the opposite side
    assign fwd[NSIDES-1-i] = {src[i][LW-1:1], pass_par ? src[i][0] : gen_src[i]};

    ptx_hold_latch #(.W(LW)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .le      (le[i]),
      .use_drv (drives[i]),
      .d_raw   (raw[i]),
      .d_drv   (fwd[i]),
      .q_src   (src[i]),
      .q_chk   (chk[i])
    );

    ptx_parity #(.W(DATA_W)) u_gen_chk (
      .data (chk[i][LW-1:1]),
      .odd  (odd_par),
      .par  (gen_chk[i])
    );

    assign bad_n[i] = ~(gen_chk[i] ^ chk[i][0]);
  end

  assign a_oe               = drives[SIDE_A];
  assign b_oe               = drives[SIDE_B];
  assign {a_out, a_par_out} = drives[SIDE_A] ? fwd[SIDE_A] : '0;
  assign {b_out, b_par_out} = drives[SIDE_B] ? fwd[SIDE_B] : '0;
  assign a_bad_n            = bad_n[SIDE_A];
  assign b_bad_n            = bad_n[SIDE_B];
endmodule

// File: rtl/ptx_xcvr_chk.sv
module ptx_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_a2b_n,
  input logic              pass_par,
  input logic              odd_par,
  input logic              a_le,
  input logic              b_le,
  input logic [DATA_W-1:0] a_out,
  input logic              a_par_out,
  input logic              a_oe,
  input logic [DATA_W-1:0] b_out,
  input logic              b_par_out,
  input logic              b_oe,
  input logic              a_bad_n,
  input logic              b_bad_n
);
  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe)); // R1

  AST_A2B_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a2b_n |-> b_oe); // R1

  AST_IDLE_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> (a_out == '0 && !a_par_out)); // R10

  AST_IDLE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (b_out == '0 && !b_par_out)); // R10

  AST_GEN_SENSE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !pass_par) |-> ((^{b_out, b_par_out}) == odd_par)); // R5

  AST_GEN_SENSE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && !pass_par) |-> ((^{a_out, a_par_out}) == odd_par)); // R5

  AST_LOOP_CLEAN_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !pass_par && b_le) |-> b_bad_n); // R8

  AST_LOOP_CLEAN_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && !pass_par && a_le) |-> a_bad_n); // R8

  AST_HOLD_B_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && $past(b_oe) && !a_le && $past(!a_le)) |-> $stable(b_out)); // R7
endmodule

bind ptx_xcvr ptx_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_a2b_n  (en_a2b_n),
  .pass_par  (pass_par),
  .odd_par   (odd_par),
  .a_le      (a_le),
  .b_le      (b_le),
  .a_out     (a_out),
  .a_par_out (a_par_out),
  .a_oe      (a_oe),
  .b_out     (b_out),
  .b_par_out (b_par_out),
  .b_oe      (b_oe),
  .a_bad_n   (a_bad_n),
  .b_bad_n   (b_bad_n)
);

// File: tb/ptx_xcvr_tb_top.sv
`timescale 1ns/1ps
module ptx_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, en_a2b_n, en_b2a_n, pass_par, odd_par, a_le, b_le;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_par_in, b_par_in, a_par_out, b_par_out, a_oe, b_oe, a_bad_n, b_bad_n;

  ptx_xcvr #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_a2b_n(en_a2b_n), .en_b2a_n(en_b2a_n),
    .pass_par(pass_par), .odd_par(odd_par), .a_le(a_le), .b_le(b_le),
    .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
    .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
    .a_bad_n(a_bad_n), .b_bad_n(b_bad_n)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference state: words held by each side's latch
  logic [W:0] mh_a = '0, mh_b = '0;
  logic [W:0] la_e, lb_e, fa_e, fb_e;
  logic       aoe_e, boe_e, ea_e, eb_e;

  task automatic predict();
    logic [W:0] sa, sb;
    boe_e = !en_a2b_n;
    aoe_e = en_a2b_n && !en_b2a_n;
    sa = a_le ? {a_in, a_par_in} : mh_a;
    sb = b_le ? {b_in, b_par_in} : mh_b;
    fa_e = '0; fb_e = '0; la_e = sa; lb_e = sb;
    if (boe_e) begin
      fb_e = {sa[W:1], pass_par ? sa[0] : ((^sa[W:1]) ^ odd_par)};
      if (b_le) lb_e = fb_e;
    end else if (aoe_e) begin
      fa_e = {sb[W:1], pass_par ? sb[0] : ((^sb[W:1]) ^ odd_par)};
      if (a_le) la_e = fa_e;
    end
    ea_e = (((^la_e[W:1]) ^ odd_par) == la_e[0]);
    eb_e = (((^lb_e[W:1]) ^ odd_par) == lb_e[0]);
  endtask

  task automatic check_model();
    string ptag;
    ptag = pass_par ? "R2/R4" : "R2/R3";
    chk(a_oe == aoe_e && b_oe == boe_e, "R1", {a_oe, b_oe}, {aoe_e, boe_e});
    chk({a_out, a_par_out} == fa_e, aoe_e ? ptag : "R10", {a_out, a_par_out}, fa_e);
    chk({b_out, b_par_out} == fb_e, boe_e ? ptag : "R10", {b_out, b_par_out}, fb_e);
    chk(a_bad_n == ea_e, "R6", a_bad_n, ea_e);
    chk(b_bad_n == eb_e, "R6", b_bad_n, eb_e);
  endtask

  task automatic close_cycle();
    @(posedge clk);
    if (a_le) mh_a = la_e;
    if (b_le) mh_b = lb_e;
  endtask

  // {en_a2b_n,en_b2a_n,pass_par,odd_par}, a, a_par, b, b_par, {a_oe,b_oe,drv_par,a_bad_n,b_bad_n}
  localparam logic [26:0] TBL [11] = '{
    {4'b0100, 8'h00, 1'b0, 8'hFF, 1'b0, 5'b01011},
    {4'b0101, 8'h01, 1'b0, 8'hFF, 1'b0, 5'b01011},
    {4'b0100, 8'h03, 1'b1, 8'hFF, 1'b0, 5'b01001},
    {4'b0110, 8'h07, 1'b0, 8'hFF, 1'b0, 5'b01000},
    {4'b0111, 8'h0F, 1'b1, 8'hFF, 1'b0, 5'b01111},
    {4'b1000, 8'h3C, 1'b0, 8'hA5, 1'b1, 5'b10010},
    {4'b1011, 8'h3C, 1'b0, 8'h80, 1'b0, 5'b10011},
    {4'b1010, 8'h3C, 1'b0, 8'h80, 1'b0, 5'b10000},
    {4'b0000, 8'h11, 1'b0, 8'hFF, 1'b0, 5'b01011},
    {4'b1100, 8'h01, 1'b0, 8'h03, 1'b0, 5'b00001},
    {4'b1101, 8'h00, 1'b1, 8'h00, 1'b0, 5'b00010}
  };

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_a2b_n = 1'b1; en_b2a_n = 1'b1; pass_par = 1'b0; odd_par = 1'b0;
    a_le = 1'b0; b_le = 1'b0; a_in = 8'hC3; a_par_in = 1'b1; b_in = 8'h5E; b_par_in = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!a_oe && !b_oe && a_out == '0 && b_out == '0, "R9", {a_oe, b_oe, a_out, b_out}, '0);
    chk(a_bad_n && b_bad_n, "R9", {a_bad_n, b_bad_n}, 2'b11);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(a_bad_n && b_bad_n && !a_par_out && !b_par_out, "R9", {a_bad_n, b_bad_n, a_par_out, b_par_out}, 4'b1100);

    // table of vectors, both latches open
    foreach (TBL[k]) begin
      logic [26:0] v;
      v = TBL[k];
      @(negedge clk);
      {en_a2b_n, en_b2a_n, pass_par, odd_par} = v[26:23];
      a_in = v[22:15]; a_par_in = v[14]; b_in = v[13:6]; b_par_in = v[5];
      a_le = 1'b1; b_le = 1'b1;
      #1;
      predict();
      chk(a_oe == v[4] && b_oe == v[3], "R1", {a_oe, b_oe}, v[4:3]);
      chk((a_par_out | b_par_out) == v[2], odd_par ? "R5" : (pass_par ? "R4" : "R3"),
          a_par_out | b_par_out, v[2]);
      chk(a_bad_n == v[1], "R6", a_bad_n, v[1]);
      chk(b_bad_n == v[0], "R6", b_bad_n, v[0]);
      check_model();
      close_cycle();
    end

    // sweep of all control combinations, parity errors injected by round
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 64; c++) begin
        logic [5:0] cc;
        cc = 6'(c);
        @(negedge clk);
        {en_a2b_n, en_b2a_n, pass_par, odd_par, a_le, b_le} = cc;
        a_in = 8'(c * 37 + r * 91 + 5);
        b_in = 8'(c * 53 + r * 29 + 17);
        a_par_in = (^a_in) ^ odd_par ^ r[0];
        b_par_in = (^b_in) ^ odd_par ^ r[1];
        #1;
        predict();
        check_model();
        close_cycle();
      end
    end

    // hold: capture 5A on side A, then close and disturb the input
    @(negedge clk);
    en_a2b_n = 1'b0; en_b2a_n = 1'b1; pass_par = 1'b0; odd_par = 1'b0;
    a_le = 1'b1; b_le = 1'b0; a_in = 8'h5A; a_par_in = 1'b0;
    #1; predict(); check_model(); close_cycle();
    @(negedge clk);
    a_le = 1'b0; a_in = 8'hFF; a_par_in = 1'b1;
    #1; predict();
    chk(b_out == 8'h5A, "R7", b_out, 8'h5A);
    chk(b_par_out == 1'b0, "R7", b_par_out, 1'b0);
    chk(a_bad_n == 1'b1, "R7", a_bad_n, 1'b1);
    close_cycle();

    // loopback onto the driven side
    @(negedge clk);
    en_a2b_n = 1'b0; pass_par = 1'b0; odd_par = 1'b1;
    a_le = 1'b1; b_le = 1'b1; a_in = 8'h07; a_par_in = 1'b1;
    #1; predict();
    chk(b_bad_n == 1'b1, "R8", b_bad_n, 1'b1);
    chk(a_bad_n == 1'b0, "R6", a_bad_n, 1'b0);
    close_cycle();
    @(negedge clk);
    pass_par = 1'b1;
    #1; predict();
    chk(b_par_out == 1'b1, "R4", b_par_out, 1'b1);
    chk(b_bad_n == 1'b0, "R8", b_bad_n, 1'b0);
    close_cycle();

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule